// File: doc/BRIEF.md
# Selectable-Depth Serial Bit Elastic Store

This block is a one-bit-wide elastic buffer placed between a line clock and a smoothed, dejittered read clock. Bits arrive on `wr_clk`, which is the clock that comes with the data of the buffered direction. They leave on `rd_clk`, which is supplied separately. A two-bit mode input selects one of three settings: a 16-entry store, a 32-entry store, or a bypass in which both directions pass straight through. A direction select places the store in either the receive or the transmit path. The other path is wired through without buffering.

The write and read pointers cross between the two clock domains in Gray code through two-flop synchronizers. Each domain computes its own fill level from its local pointer and the synchronized copy of the opposite pointer. A sticky limit flag rises when the fill comes within two entries of full or of empty. A single-cycle status read in the read domain does three things: it returns the flag, clears it, and recenters the store. A mode change or a reset also recenters the store. Recentering places the read pointer half the selected depth behind the write pointer, with allowance for the synchronizer lag. It then holds the output at 0 until the first valid read, and masks the flag for a short settling window.

The read-domain controller has four states:
- `ST_BYPASS` is entered whenever the mode is 00.
- `ST_RECENTER` loads the read pointer. It is entered from any state on a change to a non-zero mode, from `ST_BYPASS`, or on a status read in `ST_SETTLE` or `ST_RUN`.
- `ST_SETTLE` reads with the flag masked. It is always entered after `ST_RECENTER`.
- `ST_RUN` is normal operation with flag setting enabled. It is entered from `ST_SETTLE` once the guard count expires.

Top module: `bit_elastic_store`

## Requirements
- R1: Mode code 00 is bypass. `rx_dout` equals `rx_din` and `tx_dout` equals `tx_din` combinationally, and `limit_flag` is 0 one read cycle later.
- R2: Mode code 01 selects a depth D of 16. With equal clock rates, the buffered output reproduces the buffered input delayed by a fixed count between D/2-3 and D/2+4 read cycles.
- R3: Mode codes 10 and 11 both select a depth D of 32, with the same delayed reproduction and delay window as R2.
- R4: `path_tx`=0 buffers the receive path (`rx_din` to `rx_dout`) and passes `tx_din` to `tx_dout` combinationally. `path_tx`=1 buffers the transmit path and passes the receive path through.
- R5: Data is written on every `wr_clk` edge and read on every `rd_clk` edge. When the read clock runs faster than the write clock, `limit_flag` rises once the fill nears empty (within two entries).
- R6: When the write clock runs faster than the read clock, `limit_flag` rises once the fill nears full (within two entries of D).
- R7: Once set, `limit_flag` stays at 1 until a status read or bypass, even if the clocks return to equal rates. It is 0 while the clocks are equal and the store is centred.
- R8: A one-cycle `stat_rd` pulse loads `stat_q` at that `rd_clk` edge with the flag value before the read, and clears `limit_flag` at that same edge.
- R9: A status read recenters the store. The buffered output is 0 two read edges after the strobe. With equal clocks, the flag then stays 0 and the delay is back inside the R2/R3 window.
- R10: A change between non-zero mode codes recenters the store at the new depth.
- R11: During reset, `limit_flag`, `stat_q` and the buffered output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Line clock of the buffered direction (write side) |
| rd_clk | input | 1 | Dejittered read clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| mode | input | 2 | 00 bypass, 01 depth 16, 10/11 depth 32 |
| path_tx | input | 1 | 0 buffers the receive path, 1 buffers the transmit path |
| rx_din | input | 1 | Receive-direction input bit |
| tx_din | input | 1 | Transmit-direction input bit |
| stat_rd | input | 1 | Single-cycle status read strobe (rd_clk domain) |
| rx_dout | output | 1 | Receive-direction output bit |
| tx_dout | output | 1 | Transmit-direction output bit |
| limit_flag | output | 1 | Sticky near-full/near-empty flag |
| stat_q | output | 1 | Flag value captured by the last status read |

## Verification
The bench builds the block with its default parameters: a 32-entry large store, a 16-entry small store, a two-entry margin and a 12-cycle guard. At these depths a 10 % clock-rate mismatch drains or fills the store to the margin within tens of cycles, so both flag directions, the sticky hold and the recenter on status read are each reached in a few hundred cycles. The delay window is small enough for the bench to search every candidate lag against a pseudo-random bit history, for each depth and each path.

// File: rtl/bes_pkg.sv
package bes_pkg;

    localparam logic [1:0] MODE_OFF  = 2'b00;
    localparam logic [1:0] MODE_D16  = 2'b01;

    typedef enum logic [1:0] {
        ST_BYPASS   = 2'd0,
        ST_RECENTER = 2'd1,
        ST_SETTLE   = 2'd2,
        ST_RUN      = 2'd3
    } rd_state_e;

endpackage

// File: rtl/bes_sync.sv
module bes_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/bes_gray2bin.sv
module bes_gray2bin #(
    parameter int W = 6
) (
    input  logic [W-1:0] gray,
    output logic [W-1:0] bin
);
    // each binary bit is the parity of the gray bits at and above it
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bin[i] = ^(gray >> i);
    end
endmodule

// File: rtl/bes_wr_side.sv
module bes_wr_side
    import bes_pkg::*;
#(
    parameter int MAX_DEPTH   = 32,
    parameter int SMALL_DEPTH = 16,
    parameter int MARGIN      = 2,
    parameter int AW          = $clog2(MAX_DEPTH) + 1
) (
    input  logic                 wr_clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode,
    input  logic                 din,
    input  logic [AW-1:0]        rd_gray_s,
    output logic [AW-1:0]        wr_gray_q,
    output logic [MAX_DEPTH-1:0] mem_q,
    output logic                 near_full_q
);
    localparam int IW = AW - 1;

    logic [AW-1:0] wr_bin_q;
    logic [AW-1:0] wr_bin_nx;
    logic [AW-1:0] rd_bin_s;
    logic [AW-1:0] depth;
    logic [AW-1:0] fill_w;
    logic [IW-1:0] idx_mask;
    logic [IW-1:0] wr_idx;
    logic          active;

    bes_gray2bin #(.W(AW)) u_rd_g2b (
        .gray (rd_gray_s),
        .bin  (rd_bin_s)
    );

    assign active    = (mode != MODE_OFF);
    assign depth     = (mode == MODE_D16) ? AW'(SMALL_DEPTH) : AW'(MAX_DEPTH);
    assign idx_mask  = IW'(depth - 1'b1);
    assign wr_idx    = wr_bin_q[IW-1:0] & idx_mask;
    assign wr_bin_nx = wr_bin_q + 1'b1;
    assign fill_w    = wr_bin_q - rd_bin_s;

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_bin_q    <= '0;
            wr_gray_q   <= '0;
            mem_q       <= '0;
            near_full_q <= 1'b0;
        end else if (active) begin
            mem_q[wr_idx] <= din;
            wr_bin_q      <= wr_bin_nx;
            wr_gray_q     <= wr_bin_nx ^ (wr_bin_nx >> 1);
            near_full_q   <= (fill_w >= depth - AW'(MARGIN));
        end else begin
            near_full_q   <= 1'b0;
        end
    end
endmodule

// File: rtl/bes_rd_side.sv
module bes_rd_side
    import bes_pkg::*;
#(
    parameter int MAX_DEPTH   = 32,
    parameter int SMALL_DEPTH = 16,
    parameter int MARGIN      = 2,
    parameter int GUARD       = 12,
    parameter int SYNC_SKEW   = 3,
    parameter int AW          = $clog2(MAX_DEPTH) + 1
) (
    input  logic                 rd_clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode,
    input  logic [AW-1:0]        wr_gray_s,
    input  logic [MAX_DEPTH-1:0] mem_q,
    input  logic                 near_full_s,
    input  logic                 stat_rd,
    output logic [AW-1:0]        rd_gray_q,
    output logic                 dout_q,
    output logic                 limit_flag,
    output logic                 stat_q,
    output logic                 near_empty,
    output logic                 running
);
    localparam int IW = AW - 1;
    localparam int GW = $clog2(GUARD + 1);

    rd_state_e     st_q, st_d;
    logic [1:0]    mode_q;
    logic [AW-1:0] rd_bin_q;
    logic [AW-1:0] wr_bin_s;
    logic [AW-1:0] depth;
    logic [AW-1:0] half;
    logic [AW-1:0] fill_r;
    logic [IW-1:0] idx_mask;
    logic [IW-1:0] rd_idx;
    logic [GW-1:0] guard_q;
    logic          guard_done;
    logic          mode_chg;

    bes_gray2bin #(.W(AW)) u_wr_g2b (
        .gray (wr_gray_s),
        .bin  (wr_bin_s)
    );

    assign depth      = (mode == MODE_D16) ? AW'(SMALL_DEPTH) : AW'(MAX_DEPTH);
    assign half       = depth >> 1;
    assign idx_mask   = IW'(depth - 1'b1);
    assign rd_idx     = rd_bin_q[IW-1:0] & idx_mask;
    assign fill_r     = wr_bin_s - rd_bin_q;
    assign near_empty = (fill_r <= AW'(MARGIN));
    assign guard_done = (guard_q == GW'(GUARD));
    assign mode_chg   = (mode != mode_q);
    assign running    = (st_q == ST_RUN);

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (mode == MODE_OFF) begin
            st_d = ST_BYPASS;
        end else if (mode_chg) begin
            st_d = ST_RECENTER;
        end else begin
            unique case (st_q)
                ST_BYPASS:   st_d = ST_RECENTER;
                ST_RECENTER: st_d = ST_SETTLE;
                ST_SETTLE: begin
                    if (stat_rd)         st_d = ST_RECENTER;
                    else if (guard_done) st_d = ST_RUN;
                end
                ST_RUN: begin
                    if (stat_rd)         st_d = ST_RECENTER;
                end
                default:                 st_d = ST_BYPASS;
            endcase
        end
    end

    // state register
    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_BYPASS;
            mode_q <= MODE_OFF;
        end else begin
            st_q   <= st_d;
            mode_q <= mode;
        end
    end

    // outputs and datapath
    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_bin_q   <= '0;
            rd_gray_q  <= '0;
            dout_q     <= 1'b0;
            guard_q    <= '0;
            limit_flag <= 1'b0;
            stat_q     <= 1'b0;
        end else begin
            rd_gray_q <= rd_bin_q ^ (rd_bin_q >> 1);
            if (stat_rd) begin
                stat_q <= limit_flag;
            end
            unique case (st_q)
                ST_BYPASS: begin
                    dout_q  <= 1'b0;
                    guard_q <= '0;
                end
                ST_RECENTER: begin
                    rd_bin_q <= wr_bin_s - half + AW'(SYNC_SKEW);
                    dout_q   <= 1'b0;
                    guard_q  <= '0;
                end
                ST_SETTLE: begin
                    dout_q   <= mem_q[rd_idx];
                    rd_bin_q <= rd_bin_q + 1'b1;
                    if (!guard_done) begin
                        guard_q <= guard_q + 1'b1;
                    end
                end
                ST_RUN: begin
                    dout_q   <= mem_q[rd_idx];
                    rd_bin_q <= rd_bin_q + 1'b1;
                end
                default: begin
                    dout_q <= 1'b0;
                end
            endcase
            if ((mode == MODE_OFF) || stat_rd) begin
                limit_flag <= 1'b0;
            end else if (running && (near_empty || near_full_s)) begin
                limit_flag <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/bit_elastic_store.sv
module bit_elastic_store
    import bes_pkg::*;
#(
    parameter int MAX_DEPTH   = 32,
    parameter int SMALL_DEPTH = 16,
    parameter int MARGIN      = 2,
    parameter int GUARD       = 12,
    parameter int SYNC_SKEW   = 3
) (
    input  logic       wr_clk,
    input  logic       rd_clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       path_tx,
    input  logic       rx_din,
    input  logic       tx_din,
    input  logic       stat_rd,
    output logic       rx_dout,
    output logic       tx_dout,
    output logic       limit_flag,
    output logic       stat_q
);
    localparam int AW = $clog2(MAX_DEPTH) + 1;

    logic [AW-1:0]        wr_gray_q;
    logic [AW-1:0]        wr_gray_s;
    logic [AW-1:0]        rd_gray_q;
    logic [AW-1:0]        rd_gray_s;
    logic [MAX_DEPTH-1:0] mem_q;
    logic                 near_full_q;
    logic                 near_full_s;
    logic                 near_empty;
    logic                 running;
    logic                 buf_q;
    logic                 wr_din;
    logic                 bypass;

    assign bypass = (mode == MODE_OFF);
    assign wr_din = path_tx ? tx_din : rx_din;

    bes_wr_side #(
        .MAX_DEPTH   (MAX_DEPTH),
        .SMALL_DEPTH (SMALL_DEPTH),
        .MARGIN      (MARGIN),
        .AW          (AW)
    ) u_wr (
        .wr_clk      (wr_clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .din         (wr_din),
        .rd_gray_s   (rd_gray_s),
        .wr_gray_q   (wr_gray_q),
        .mem_q       (mem_q),
        .near_full_q (near_full_q)
    );

    bes_sync #(.W(AW)) u_sync_rd2wr (
        .clk   (wr_clk),
        .rst_n (rst_n),
        .d     (rd_gray_q),
        .q     (rd_gray_s)
    );

    bes_sync #(.W(AW)) u_sync_wr2rd (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .d     (wr_gray_q),
        .q     (wr_gray_s)
    );

    bes_sync #(.W(1)) u_sync_full (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .d     (near_full_q),
        .q     (near_full_s)
    );

    bes_rd_side #(
        .MAX_DEPTH   (MAX_DEPTH),
        .SMALL_DEPTH (SMALL_DEPTH),
        .MARGIN      (MARGIN),
        .GUARD       (GUARD),
        .SYNC_SKEW   (SYNC_SKEW),
        .AW          (AW)
    ) u_rd (
        .rd_clk      (rd_clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .wr_gray_s   (wr_gray_s),
        .mem_q       (mem_q),
        .near_full_s (near_full_s),
        .stat_rd     (stat_rd),
        .rd_gray_q   (rd_gray_q),
        .dout_q      (buf_q),
        .limit_flag  (limit_flag),
        .stat_q      (stat_q),
        .near_empty  (near_empty),
        .running     (running)
    );

    assign rx_dout = (bypass || path_tx)  ? rx_din : buf_q;
    assign tx_dout = (bypass || !path_tx) ? tx_din : buf_q;
endmodule

// File: rtl/bit_elastic_store_chk.sv
module bit_elastic_store_chk #(
    parameter int AW = 6
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst_n,
    input logic [1:0]    mode,
    input logic          path_tx,
    input logic          stat_rd,
    input logic          limit_flag,
    input logic          stat_q,
    input logic          rx_dout,
    input logic          tx_dout,
    input logic          near_empty,
    input logic          near_full_s,
    input logic          running,
    input logic [AW-1:0] wr_gray_q
);
    AST_BYPASS_NOFLAG: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (mode == 2'b00) |=> !limit_flag); // R1

    AST_GRAY_STEP: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (mode != 2'b00) |=> ($countones(wr_gray_q ^ $past(wr_gray_q)) == 1)); // R5

    AST_RISE_CAUSE: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $rose(limit_flag) |-> $past(running && (near_empty || near_full_s))); // R6

    AST_FLAG_STICKY: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (limit_flag && !stat_rd && mode != 2'b00) |=> limit_flag); // R7

    AST_READ_CLEARS: assert property (@(posedge rd_clk) disable iff (!rst_n)
        stat_rd |=> !limit_flag); // R8

    AST_STAT_VALUE: assert property (@(posedge rd_clk) disable iff (!rst_n)
        stat_rd |=> (stat_q == $past(limit_flag))); // R8

    AST_HOLD_ZERO: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (stat_rd && running) |=> ##1
        ((mode == 2'b00) || (path_tx ? (tx_dout == 1'b0) : (rx_dout == 1'b0)))); // R9
endmodule

bind bit_elastic_store bit_elastic_store_chk #(.AW(AW)) u_chk (
    .wr_clk      (wr_clk),
    .rd_clk      (rd_clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .path_tx     (path_tx),
    .stat_rd     (stat_rd),
    .limit_flag  (limit_flag),
    .stat_q      (stat_q),
    .rx_dout     (rx_dout),
    .tx_dout     (tx_dout),
    .near_empty  (near_empty),
    .near_full_s (near_full_s),
    .running     (running),
    .wr_gray_q   (wr_gray_q)
);

// File: tb/bit_elastic_store_test.sv
`timescale 1ns/1ps
module bit_elastic_store_test;

    logic       wr_clk = 1'b0;
    logic       rd_clk = 1'b0;
    logic       rst_n  = 1'b0;
    logic [1:0] mode   = 2'b10;
    logic       path_tx = 1'b0;
    logic       rx_din = 1'b0;
    logic       tx_din = 1'b0;
    logic       stat_rd = 1'b0;
    logic       rx_dout, tx_dout, limit_flag, stat_q;

    int  n_chk  = 0;
    int  n_fail = 0;
    int  wr_n   = 0;
    int  rd_n   = 0;
    realtime wr_half = 2.5;
    bit  hist_rx [0:65535];
    bit  hist_tx [0:65535];
    logic [15:0] lf_rx = 16'hACE1;
    logic [15:0] lf_tx = 16'h1D2B;

    bit_elastic_store uut (
        .wr_clk     (wr_clk),
        .rd_clk     (rd_clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .path_tx    (path_tx),
        .rx_din     (rx_din),
        .tx_din     (tx_din),
        .stat_rd    (stat_rd),
        .rx_dout    (rx_dout),
        .tx_dout    (tx_dout),
        .limit_flag (limit_flag),
        .stat_q     (stat_q)
    );

    // 200 MHz read clock
    initial forever #2.5 rd_clk = ~rd_clk;
    initial begin
        #1.3;
        forever #(wr_half) wr_clk = ~wr_clk;
    end

    // pseudo-random input bits, changed away from the write edge
    initial forever begin
        @(negedge wr_clk);
        lf_rx  = {lf_rx[14:0], lf_rx[15] ^ lf_rx[13] ^ lf_rx[12] ^ lf_rx[10]};
        lf_tx  = {lf_tx[14:0], lf_tx[15] ^ lf_tx[13] ^ lf_tx[12] ^ lf_tx[10]};
        rx_din = lf_rx[0];
        tx_din = lf_tx[0];
    end

    initial forever begin
        @(posedge wr_clk);
        hist_rx[wr_n & 16'hFFFF] = rx_din;
        hist_tx[wr_n & 16'hFFFF] = tx_din;
        wr_n++;
    end

    initial forever begin
        @(posedge rd_clk);
        rd_n++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic rd_wait(input int n);
        repeat (n) @(negedge rd_clk);
    endtask

    // search every lag of the window for one that matches 48 samples
    task automatic check_lag(input int d, input bit on_tx, input string req);
        int  lo;
        int  off;
        bit  cand [0:7];
        int  found;
        lo = d / 2 - 3;
        for (int k = 0; k < 8; k++) cand[k] = 1'b1;
        @(negedge rd_clk);
        off = wr_n - rd_n;
        for (int s = 0; s < 48; s++) begin
            @(negedge rd_clk);
            for (int k = 0; k < 8; k++) begin
                int  idx;
                bit  e;
                bit  o;
                idx = (rd_n + off - (lo + k)) & 16'hFFFF;
                e   = on_tx ? hist_tx[idx] : hist_rx[idx];
                o   = on_tx ? tx_dout : rx_dout;
                if (o != e) cand[k] = 1'b0;
            end
        end
        found = -1;
        for (int k = 0; k < 8; k++) if (cand[k] && found < 0) found = lo + k;
        chk(found >= 0, req, found, lo);
    endtask

    task automatic passthru(input string req);
        int bad;
        bad = 0;
        for (int s = 0; s < 20; s++) begin
            @(negedge rd_clk);
            if (path_tx || mode == 2'b00) begin
                if (rx_dout != rx_din) bad++;
            end
            if (!path_tx || mode == 2'b00) begin
                if (tx_dout != tx_din) bad++;
            end
        end
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic strobe(output bit q, output bit f);
        @(negedge rd_clk);
        stat_rd = 1'b1;
        @(negedge rd_clk);
        stat_rd = 1'b0;
        q = stat_q;
        f = limit_flag;
    endtask

    task automatic wait_flag(input string req);
        int t;
        t = 0;
        while (!limit_flag && t < 600) begin
            @(negedge rd_clk);
            t++;
        end
        chk(limit_flag == 1'b1, req, int'(limit_flag), 1);
    endtask

    task automatic flag_quiet(input int n, input string req);
        int hits;
        hits = 0;
        for (int s = 0; s < n; s++) begin
            @(negedge rd_clk);
            if (limit_flag) hits++;
        end
        chk(hits == 0, req, hits, 0);
    endtask

    initial begin
        repeat (200000) @(posedge rd_clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit q, f;
        // R11: reset state
        rd_wait(6);
        chk(limit_flag == 1'b0, "R11 flag", int'(limit_flag), 0);
        chk(stat_q == 1'b0, "R11 stat_q", int'(stat_q), 0);
        chk(rx_dout == 1'b0, "R11 buffered out", int'(rx_dout), 0);
        rst_n = 1'b1;

        // R3: depth 32 via code 10, then code 11
        rd_wait(80);
        check_lag(32, 1'b0, "R3 mode10 delay");
        flag_quiet(60, "R7 centred quiet");
        mode = 2'b11;
        rd_wait(80);
        check_lag(32, 1'b0, "R3 R10 mode11 delay");

        // R2, R10: switch to depth 16
        mode = 2'b01;
        rd_wait(80);
        check_lag(16, 1'b0, "R2 R10 mode01 delay");
        flag_quiet(60, "R10 no flag after recenter");

        // R4: transmit path buffered, receive passes through
        path_tx = 1'b1;
        rd_wait(60);
        check_lag(16, 1'b1, "R4 tx buffered delay");
        passthru("R4 rx passthrough");
        path_tx = 1'b0;
        rd_wait(60);
        check_lag(16, 1'b0, "R4 rx buffered delay");
        passthru("R4 tx passthrough");

        // R1: bypass
        mode = 2'b00;
        rd_wait(3);
        passthru("R1 bypass passthrough");
        chk(limit_flag == 1'b0, "R1 bypass flag", int'(limit_flag), 0);

        // R5: read faster than write drains the store
        mode = 2'b01;
        rd_wait(80);
        strobe(q, f);
        chk(q == 1'b0, "R8 read of clear flag", int'(q), 0);
        rd_wait(40);
        wr_half = 2.75;
        wait_flag("R5 near empty flag");
        wr_half = 2.5;
        rd_wait(60);
        chk(limit_flag == 1'b1, "R7 sticky", int'(limit_flag), 1);

        // R8, R9: status read returns, clears and recenters
        strobe(q, f);
        chk(q == 1'b1, "R8 stat_q", int'(q), 1);
        chk(f == 1'b0, "R8 flag cleared", int'(f), 0);
        @(negedge rd_clk);
        chk(rx_dout == 1'b0, "R9 output zero", int'(rx_dout), 0);
        flag_quiet(80, "R9 quiet after recenter");
        check_lag(16, 1'b0, "R9 delay after recenter");

        // R6: write faster than read fills the store (depth 32)
        mode = 2'b10;
        rd_wait(80);
        wr_half = 2.25;
        wait_flag("R6 near full flag");
        wr_half = 2.5;
        rd_wait(40);
        chk(limit_flag == 1'b1, "R7 sticky full", int'(limit_flag), 1);
        strobe(q, f);
        chk(q == 1'b1, "R8 stat_q full", int'(q), 1);
        chk(f == 1'b0, "R8 flag cleared full", int'(f), 0);
        flag_quiet(80, "R9 quiet after recenter full");
        check_lag(32, 1'b0, "R9 delay after recenter full");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule